// File: doc/BRIEF.md
# Video Register Command Decoder

This block parses a byte stream of display-controller commands and turns register-write commands into the state of an on-chip register file. Every command opens with the prefix byte 0xAF and continues with an opcode byte. A register write carries one address byte and one value byte.

A special address gates the register file. Once it is locked, writes collect in shadow copies and the outputs hold steady. Unlocking copies every shadow byte to the active copy in one clock cycle, so a complete mode change reaches the outputs at once.

The decoder also recognises the fixed-length copy command. It consumes the command and reports the parsed addresses and pixel count for one cycle. A byte that breaks the framing sets a sticky error flag, and the parser then resynchronises on the next prefix byte. The active register values are decoded into named fields: colour depth, blanking mode, two 24-bit base pointers, twelve timing words and the pixel-clock word.

Top module: `vidcmd_decoder`

## Requirements
- R1: After reset, all register outputs read zero, `locked`, `protoErr` and `copyValid` are low, and `inReady` is high.
- R2: With the set unlocked, the sequence AF 20 <addr> <val> updates the active byte one cycle after the value byte is taken. `base16` is {0x20,0x21,0x22} and `base8` is {0x26,0x27,0x28}, with the lowest address as the most significant byte.
- R3: Timing word k (k = 0..11) is {reg[0x01+2k], reg[0x02+2k]}, with the high byte at the lower address. `pixClk` is {reg[0x1C], reg[0x1B]}, with the low byte at 0x1B.
- R4: Writing 0x00 to address 0xFF raises `locked`. While `locked` stays high, register writes change no register output.
- R5: Writing 0xFF to address 0xFF clears `locked` and moves every shadow byte to the outputs in the same cycle.
- R6: `blankMode` reflects address 0x1F (0x00 syncs on, 0x01 syncs off, 0x05 standby, 0x07 powerdown). `depthSel` reflects address 0x00 (0 = 16 bpp, 1 = 24 bpp).
- R7: Opcode 0x6A takes seven more bytes: a 3-byte source (MSB first), a 1-byte count and a 3-byte destination (MSB first). `copyValid` is high for exactly the one cycle after the ninth byte, and the fields are valid in that cycle.
- R8: Bytes inside a copy command are never treated as a prefix or as register writes.
- R9: A first byte other than 0xAF sets `protoErr`. It stays set until reset, and bytes are discarded until the next 0xAF.
- R10: An opcode other than 0x20 or 0x6A sets `protoErr`, and the parser returns to waiting for a prefix.
- R11: A byte is taken only in a cycle with `inValid` high. Idle cycles inside a command do not disturb it.
- R12: Writes to addresses at or above the register file size (48), other than 0xFF, have no effect. A value other than 0x00 or 0xFF written to 0xFF does not change `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Command byte valid |
| inData | input | 8 | Command byte |
| inReady | output | 1 | Byte accepted (always high) |
| locked | output | 1 | Register set locked |
| protoErr | output | 1 | Sticky framing error |
| depthSel | output | 8 | Colour depth select byte |
| blankMode | output | 8 | Blanking mode byte |
| base16 | output | 24 | 16 bpp base pointer |
| base8 | output | 24 | 8 bpp base pointer |
| timingWords | output | 12x16 | Timing words, high byte at lower address |
| pixClk | output | 16 | Pixel clock word, 5 kHz units |
| copyValid | output | 1 | One-cycle copy command pulse |
| copySrc | output | 24 | Copy source address |
| copyCount | output | 8 | Copy pixel count |
| copyDst | output | 24 | Copy destination address |

## Verification
If the parser state is wrong, the next command lands on the wrong byte. That shows at the ports within one command: a register output takes a value that was never written, a copy pulse comes early or late, or `protoErr` is raised on a well-formed stream. A wrong shadow or lock state stays hidden until the unlock. At that point the outputs jump to values other than those written under lock, so each lock test checks both during the lock and right after the unlock. Copies carry payload bytes that look like a register write, which exposes any parser that lets a copy leak into the register file.

// File: rtl/vidcmd_pkg.sv
package vidcmd_pkg;
  localparam logic [7:0] PREFIX_BYTE = 8'hAF;
  localparam logic [7:0] OP_REGWR    = 8'h20;
  localparam logic [7:0] OP_COPY     = 8'h6A;
  localparam logic [7:0] LOCK_ADDR   = 8'hFF;
  localparam logic [7:0] LOCK_VAL    = 8'h00;
  localparam logic [7:0] UNLOCK_VAL  = 8'hFF;
  localparam int COPY_BODY = 7;   // bytes after opcode

  localparam int ADDR_DEPTH  = 8'h00;
  localparam int ADDR_WORD0  = 8'h01;
  localparam int ADDR_BLANK  = 8'h1F;
  localparam int ADDR_PCLK   = 8'h1B;
  localparam int ADDR_BASE16 = 8'h20;
  localparam int ADDR_BASE8  = 8'h26;

  typedef enum logic [2:0] {
    S_PREFIX, S_OPCODE, S_ADDR, S_VALUE, S_COPY
  } parse_state_t;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
    logic       lock;
    logic       commit;
    logic       shift;
    logic       fire;
  } strobe_t;
endpackage

// File: rtl/vidcmd_ctrl.sv
module vidcmd_ctrl
  import vidcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  output strobe_t    st,
  output logic       protoErr
);
  localparam int CW = $clog2(COPY_BODY);
  localparam logic [CW-1:0] LAST = CW'(COPY_BODY - 1);

  parse_state_t stateQ, stateN;
  logic [7:0]   addrQ, addrN;
  logic [CW-1:0] cntQ, cntN;
  logic         errQ, errN;

  always_comb begin
    stateN = stateQ;
    addrN  = addrQ;
    cntN   = cntQ;
    errN   = errQ;
    st     = '0;
    st.addr = addrQ;
    st.data = inData;
    if (inValid) begin
      unique case (stateQ)
        S_PREFIX: begin
          if (inData == PREFIX_BYTE) stateN = S_OPCODE;
          else errN = 1'b1;
        end
        S_OPCODE: begin
          if (inData == OP_REGWR) begin
            stateN = S_ADDR;
          end else if (inData == OP_COPY) begin
            stateN = S_COPY;
            cntN   = '0;
          end else begin
            errN   = 1'b1;
            stateN = S_PREFIX;
          end
        end
        S_ADDR: begin
          addrN  = inData;
          stateN = S_VALUE;
        end
        S_VALUE: begin
          if (addrQ == LOCK_ADDR) begin
            st.lock   = (inData == LOCK_VAL);
            st.commit = (inData == UNLOCK_VAL);
          end else begin
            st.wr = 1'b1;
          end
          stateN = S_PREFIX;
        end
        S_COPY: begin
          if (cntQ == LAST) begin
            st.fire = 1'b1;
            stateN  = S_PREFIX;
          end else begin
            st.shift = 1'b1;
            cntN     = cntQ + 1'b1;
          end
        end
        default: stateN = S_PREFIX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_PREFIX;
      addrQ  <= '0;
      cntQ   <= '0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateN;
      addrQ  <= addrN;
      cntQ   <= cntN;
      errQ   <= errN;
    end
  end

  assign protoErr = errQ;
endmodule

// File: rtl/vidcmd_regs.sv
module vidcmd_regs
  import vidcmd_pkg::*;
#(
  parameter int NREG = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              st,
  output logic [NREG-1:0][7:0] regsOut,
  output logic                 locked,
  output logic                 copyValid,
  output logic [23:0]          copySrc,
  output logic [7:0]           copyCount,
  output logic [23:0]          copyDst
);
  localparam int SHW = 8 * (COPY_BODY - 1);

  logic [7:0] shadowQ [NREG];
  logic [7:0] activeQ [NREG];
  logic       lockQ;
  logic [SHW-1:0] copyShQ;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] MYADDR = 8'(i);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowQ[i] <= '0;
        activeQ[i] <= '0;
      end else if (st.commit) begin
        activeQ[i] <= shadowQ[i];
      end else if (st.wr && st.addr == MYADDR) begin
        shadowQ[i] <= st.data;
        if (!lockQ) activeQ[i] <= st.data;
      end
    end
    assign regsOut[i] = activeQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockQ <= 1'b0;
    else if (st.commit) lockQ <= 1'b0;
    else if (st.lock) lockQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      copyShQ   <= '0;
      copyValid <= 1'b0;
      copySrc   <= '0;
      copyCount <= '0;
      copyDst   <= '0;
    end else begin
      copyValid <= st.fire;
      if (st.shift) copyShQ <= {copyShQ[SHW-9:0], st.data};
      if (st.fire) begin
        copySrc   <= copyShQ[47:24];
        copyCount <= copyShQ[23:16];
        copyDst   <= {copyShQ[15:0], st.data};
      end
    end
  end

  assign locked = lockQ;
endmodule

// File: rtl/vidcmd_decoder.sv
module vidcmd_decoder
  import vidcmd_pkg::*;
#(
  parameter int NREG   = 48,
  parameter int NWORDS = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [7:0]             inData,
  output logic                   inReady,
  output logic                   locked,
  output logic                   protoErr,
  output logic [7:0]             depthSel,
  output logic [7:0]             blankMode,
  output logic [23:0]            base16,
  output logic [23:0]            base8,
  output logic [NWORDS-1:0][15:0] timingWords,
  output logic [15:0]            pixClk,
  output logic                   copyValid,
  output logic [23:0]            copySrc,
  output logic [7:0]             copyCount,
  output logic [23:0]            copyDst
);
  strobe_t st;
  logic [NREG-1:0][7:0] regs;

  vidcmd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .st(st), .protoErr(protoErr)
  );

  vidcmd_regs #(.NREG(NREG)) i_regs (
    .clk(clk), .rstN(rstN), .st(st), .regsOut(regs), .locked(locked),
    .copyValid(copyValid), .copySrc(copySrc), .copyCount(copyCount),
    .copyDst(copyDst)
  );

  assign inReady   = 1'b1;
  assign depthSel  = regs[ADDR_DEPTH];
  assign blankMode = regs[ADDR_BLANK];
  assign base16    = {regs[ADDR_BASE16], regs[ADDR_BASE16+1], regs[ADDR_BASE16+2]};
  assign base8     = {regs[ADDR_BASE8], regs[ADDR_BASE8+1], regs[ADDR_BASE8+2]};
  assign pixClk    = {regs[ADDR_PCLK+1], regs[ADDR_PCLK]};

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign timingWords[k] = {regs[ADDR_WORD0+2*k], regs[ADDR_WORD0+2*k+1]};
  end

  logic unusedRegBits;
  assign unusedRegBits = ^regs;
endmodule

// File: rtl/vidcmd_checker.sv
module vidcmd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [7:0]  inData,
  input logic        locked,
  input logic        protoErr,
  input logic [7:0]  blankMode,
  input logic [23:0] base16,
  input logic [23:0] base8,
  input logic [15:0] pixClk,
  input logic        copyValid
);
  // R4: outputs frozen while the set stays locked
  p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> (!locked || ($stable(blankMode) && $stable(base16) &&
                            $stable(base8) && $stable(pixClk))));

  // R4: lock rises only on a 0x00 value byte
  p_lock_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(inValid && inData == 8'h00));

  // R5: unlock falls only on a 0xFF value byte
  p_unlock_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(inValid && inData == 8'hFF));

  // R7: copy pulse lasts one cycle and follows an accepted byte
  p_copy_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    copyValid |=> !copyValid);
  p_copy_after_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    copyValid |-> $past(inValid));

  // R9: error flag is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind vidcmd_decoder vidcmd_checker i_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
  .locked(locked), .protoErr(protoErr), .blankMode(blankMode),
  .base16(base16), .base8(base8), .pixClk(pixClk), .copyValid(copyValid)
);

// File: tb/test_vidcmd_decoder.sv
`timescale 1ns/1ps
module test_vidcmd_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, locked, protoErr, copyValid;
  logic [7:0] depthSel, blankMode, copyCount;
  logic [23:0] base16, base8, copySrc, copyDst;
  logic [11:0][15:0] timingWords;
  logic [15:0] pixClk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  vidcmd_decoder i_vidcmd_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .locked(locked), .protoErr(protoErr),
    .depthSel(depthSel), .blankMode(blankMode), .base16(base16),
    .base8(base8), .timingWords(timingWords), .pixClk(pixClk),
    .copyValid(copyValid), .copySrc(copySrc), .copyCount(copyCount),
    .copyDst(copyDst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the byte's edge
  task automatic putByte(input logic [7:0] b);
    inValid = 1'b1;
    inData  = b;
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] v);
    putByte(8'hAF); putByte(8'h20); putByte(a); putByte(v);
    inValid = 1'b0;
  endtask

  task automatic applyReset();
    inValid = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    applyReset();
    chk("R1 locked", locked, 0);
    chk("R1 protoErr", protoErr, 0);
    chk("R1 copyValid", copyValid, 0);
    chk("R1 inReady", inReady, 1);
    chk("R1 base16", base16, 0);
    chk("R1 blankMode", blankMode, 0);
    chk("R1 pixClk", pixClk, 0);
  endtask

  task automatic t_unlocked_write();
    wrReg(8'h20, 8'h12);
    chk("R2 base16 partial", base16, 32'h120000);
    wrReg(8'h21, 8'h34); wrReg(8'h22, 8'h56);
    chk("R2 base16", base16, 32'h123456);
    wrReg(8'h26, 8'hAA); wrReg(8'h27, 8'hBB); wrReg(8'h28, 8'hCC);
    chk("R2 base8", base8, 32'hAABBCC);
    wrReg(8'h1F, 8'h05);
    chk("R6 blankMode standby", blankMode, 8'h05);
    wrReg(8'h00, 8'h01);
    chk("R6 depthSel", depthSel, 8'h01);
  endtask

  task automatic t_words();
    wrReg(8'h01, 8'hAB); wrReg(8'h02, 8'hCD);
    chk("R3 word0", timingWords[0], 16'hABCD);
    wrReg(8'h17, 8'h11); wrReg(8'h18, 8'h22);
    chk("R3 word11", timingWords[11], 16'h1122);
    wrReg(8'h1B, 8'h34); wrReg(8'h1C, 8'h12);
    chk("R3 pixClk", pixClk, 16'h1234);
  endtask

  task automatic t_lock_commit();
    wrReg(8'hFF, 8'h00);
    chk("R4 locked", locked, 1);
    wrReg(8'h1F, 8'h07);
    wrReg(8'h20, 8'h99);
    chk("R4 blank held", blankMode, 8'h05);
    chk("R4 base16 held", base16, 32'h123456);
    wrReg(8'hFF, 8'hFF);
    chk("R5 unlocked", locked, 0);
    chk("R5 blank committed", blankMode, 8'h07);
    chk("R5 base16 committed", base16, 32'h993456);
  endtask

  task automatic t_copy();
    putByte(8'hAF); putByte(8'h6A);
    putByte(8'h01); putByte(8'h02); putByte(8'h03); putByte(8'h04);
    putByte(8'hAF); putByte(8'h20); putByte(8'h1F);
    inValid = 1'b0;
    chk("R7 copyValid", copyValid, 1);
    chk("R7 copySrc", copySrc, 32'h010203);
    chk("R7 copyCount", copyCount, 8'h04);
    chk("R7 copyDst", copyDst, 32'hAF201F);
    @(negedge clk);
    chk("R7 copy pulse ends", copyValid, 0);
    chk("R8 blank untouched", blankMode, 8'h07);
    wrReg(8'h1F, 8'h01);
    chk("R8 parser realigned", blankMode, 8'h01);
    chk("R8 no error", protoErr, 0);
  endtask

  task automatic t_stall();
    putByte(8'hAF); inValid = 1'b0; repeat (3) @(negedge clk);
    putByte(8'h20); inValid = 1'b0; @(negedge clk);
    putByte(8'h1F); inValid = 1'b0; repeat (2) @(negedge clk);
    putByte(8'h00); inValid = 1'b0;
    chk("R11 stalled write", blankMode, 8'h00);
    chk("R11 no error", protoErr, 0);
  endtask

  task automatic t_ignored();
    wrReg(8'h30, 8'h55);
    chk("R12 base16 kept", base16, 32'h993456);
    chk("R12 blank kept", blankMode, 8'h00);
    wrReg(8'hFF, 8'h12);
    chk("R12 not locked", locked, 0);
    wrReg(8'h1F, 8'h07);
    chk("R12 write still live", blankMode, 8'h07);
  endtask

  task automatic t_opcode_err();
    applyReset();
    putByte(8'hAF); putByte(8'h55); inValid = 1'b0;
    chk("R10 protoErr", protoErr, 1);
    wrReg(8'h1F, 8'h05);
    chk("R10 recovers", blankMode, 8'h05);
  endtask

  task automatic t_prefix_err();
    applyReset();
    putByte(8'h20); putByte(8'h1F); putByte(8'h07); inValid = 1'b0;
    chk("R9 protoErr", protoErr, 1);
    chk("R9 discarded", blankMode, 8'h00);
    wrReg(8'h1F, 8'h01);
    chk("R9 resync", blankMode, 8'h01);
    chk("R9 sticky", protoErr, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_unlocked_write();
    t_words();
    t_lock_commit();
    t_copy();
    t_stall();
    t_ignored();
    t_opcode_err();
    t_prefix_err();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule